// File: doc/BRIEF.md
# Pipelined Steady-State Genetic Algorithm Engine

This block runs a steady-state genetic algorithm entirely in hardware. A single population memory holds one chromosome and its fitness per entry. After a `start` pulse, the engine fills every entry with a pseudo-random chromosome and scores each one. It then evolves the population at a rate of one offspring per clock cycle.

Each cycle a random address is drawn and that entry is read into the first parent register. The previous first parent moves into the second parent register, so each new parent pair costs one memory read. A random template picks every child bit from one parent or the other. With a chance set by `mut_thresh`, a sparse random mask is XORed into the child. The child is scored by a block-based fitness function and then compared with the weaker of its two parents. If the child scores strictly higher, it overwrites that parent's entry. Otherwise it is dropped. Any write that hits an entry still held in the pipeline as a parent is forwarded into that pipeline stage, so survival decisions always see the entry's current fitness.

Evolution stops when the optimum is written or when `max_children` children have been evaluated. The result is then held until the next `start`. The random sources are three 32-bit LFSRs, each seeded from `seed` mixed with its own nonzero constant.

Top module: `ssga_engine`

## Requirements
- R1: While reset is held, and after it until the first start, `done`, `wr_en` and `child_valid` are 0 and `best_fit` and `gen_count` are 0.
- R2: After an accepted `start`, the first 2^ADDR_W cycles each present an initialisation write, to addresses 0, 1, 2, … in order. No `child_valid` is raised during these cycles.
- R3: Every fitness value written equals BLOCK_WT times the number of blocks b, taken as bits [b*BLOCK_W +: BLOCK_W] of the chromosome, in which all bits are 1.
- R4: Once the first child has been presented, `child_valid` is high on every cycle until `done` rises.
- R5: On a cycle with `child_valid`, `wr_en` is high exactly when `child_fit > rival_fit`. Here `rival_fit` is the lower of the two parents' fitnesses. A surviving write then carries `wr_fit == child_fit`. Outside initialisation, no write occurs without `child_valid`.
- R6: A survival write never lowers the fitness stored at its address: `wr_fit` is strictly greater than the fitness last written to `wr_addr`.
- R7: `best_fit` equals the highest `wr_fit` written since the last accepted `start`, and is updated one cycle after the write.
- R8: `done` rises after the cycle in which either the `max_children`-th child is presented or a survival write carries the optimum NBLK*BLOCK_WT, whichever comes first. It then stays high with no writes and no children until the next `start`.
- R9: `gen_count` counts presented children since the last accepted `start`, and rises one cycle after each.
- R10: Starting twice with the same `seed`, `mut_thresh` and `max_children` gives the same final `gen_count` and `best_fit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new run (accepted when idle or done) |
| seed | input | 32 | Seed mixed into the three random sources |
| mut_thresh | input | 8 | Per-child mutation chance, out of 256 |
| max_children | input | CNT_W | Child limit for a run (at least 1) |
| wr_en | output | 1 | Population write this cycle |
| wr_addr | output | ADDR_W | Entry being written |
| wr_data | output | CHROM_W | Chromosome being written |
| wr_fit | output | FIT_W | Fitness being written |
| child_valid | output | 1 | A scored child is presented this cycle |
| child_fit | output | FIT_W | Fitness of the presented child |
| rival_fit | output | FIT_W | Fitness of the weaker parent |
| best_fit | output | FIT_W | Best fitness written in this run |
| gen_count | output | CNT_W | Children evaluated in this run |
| done | output | 1 | Run finished |

## Verification
The bench builds the engine with 16-bit chromosomes, 4-bit blocks of weight 3, an 8-entry population and 16-bit counters. With these values the optimum of 12 can be reached within a few hundred children, so both stopping rules occur in a short sweep. Because only eight entries share the pipeline, an in-flight parent often has its entry overwritten before its child is judged, which exercises the forwarding paths that R6 depends on. The sweep covers four seeds (one of them cancels a seed constant to zero), three mutation chances and three child limits including the limit of one. Every write is mirrored in a shadow table.

// File: rtl/ssga_engine.sv
module ssga_engine #(
  parameter int CHROM_W  = 64,
  parameter int BLOCK_W  = 8,
  parameter int BLOCK_WT = 8,
  parameter int ADDR_W   = 6,
  parameter int CNT_W    = 32,
  parameter int FIT_W    = $clog2(CHROM_W / BLOCK_W * BLOCK_WT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        seed,
  input  logic [7:0]         mut_thresh,
  input  logic [CNT_W-1:0]   max_children,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [CHROM_W-1:0] wr_data,
  output logic [FIT_W-1:0]   wr_fit,
  output logic               child_valid,
  output logic [FIT_W-1:0]   child_fit,
  output logic [FIT_W-1:0]   rival_fit,
  output logic [FIT_W-1:0]   best_fit,
  output logic [CNT_W-1:0]   gen_count,
  output logic               done
);
  localparam int NBLK    = CHROM_W / BLOCK_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int FIT_MAX = NBLK * BLOCK_WT;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [31:0] K_A  = 32'h1D87_2B41;
  localparam logic [31:0] K_T  = 32'h6A09_E667;
  localparam logic [31:0] K_M  = 32'hBB67_AE85;

  typedef enum logic [1:0] {IDLE, INIT, RUN, STOP} phase_t;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
  endfunction

  function automatic logic [31:0] mix(input logic [31:0] s, input logic [31:0] k);
    return ((s ^ k) == 32'h0) ? k : (s ^ k);
  endfunction

  function automatic logic [FIT_W-1:0] score(input logic [CHROM_W-1:0] c);
    logic [FIT_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < NBLK; b++)
      if (&c[b*BLOCK_W +: BLOCK_W]) acc = acc + FIT_W'(BLOCK_WT);
    return acc;
  endfunction

  phase_t              state;
  logic [ADDR_W-1:0]   init_idx;
  logic [31:0]         ra, rt, rm;
  logic [CHROM_W-1:0]  mem_d [DEPTH];
  logic [FIT_W-1:0]    mem_f [DEPTH];

  logic                v1, p1_ok, v2;
  logic [ADDR_W-1:0]   a1, p1_a, p2_a;
  logic [CHROM_W-1:0]  p1_d, p2_d;
  logic [FIT_W-1:0]    p1_f, p2_f;

  logic [2:0]          st_v;
  logic [CHROM_W-1:0]  st_d  [3];
  logic [ADDR_W-1:0]   st_a1 [3];
  logic [ADDR_W-1:0]   st_a2 [3];
  logic [FIT_W-1:0]    st_f1 [3];
  logic [FIT_W-1:0]    st_f2 [3];
  logic [FIT_W-1:0]    e_fit;

  logic [CHROM_W-1:0]  tmpl, mmask, ivec;
  logic                mut_hit, weak2, surv, stop_now, hit_rd, h1, h2;
  logic [ADDR_W-1:0]   weak_a;
  logic [CNT_W:0]      gen_next;

  always_comb begin
    for (int i = 0; i < CHROM_W; i++) begin
      logic [4:0] j0, j1, j2, j3;
      j0 = 5'(i % 32);
      j1 = 5'((i * 7 + (i / 32) * 5 + 3) % 32);
      j2 = 5'((i * 5 + (i / 32) * 9 + 1) % 32);
      j3 = 5'((i * 3 + (i / 32) * 11 + 7) % 32);
      tmpl[i]  = rt[j0] ^ ra[j1];
      mmask[i] = rm[j0] & rt[j2] & ra[j3];
      ivec[i]  = ra[j0] ^ rm[j2] ^ rt[j3];
    end
  end

  assign mut_hit     = rm[7:0] < mut_thresh;
  assign weak2       = st_f2[2] <= st_f1[2];
  assign rival_fit   = weak2 ? st_f2[2] : st_f1[2];
  assign weak_a      = weak2 ? st_a2[2] : st_a1[2];
  assign child_fit   = e_fit;
  assign child_valid = st_v[2] && (state == RUN);
  assign surv        = child_valid && (e_fit > rival_fit);
  assign gen_next    = {1'b0, gen_count} + (CNT_W+1)'(1);
  assign stop_now    = child_valid &&
                       (gen_next >= {1'b0, max_children} || (surv && e_fit == FIT_W'(FIT_MAX)));

  assign wr_en   = (state == INIT) || surv;
  assign wr_addr = (state == INIT) ? init_idx : weak_a;
  assign wr_data = (state == INIT) ? ivec : st_d[2];
  assign wr_fit  = (state == INIT) ? score(ivec) : e_fit;
  assign done    = (state == STOP);

  assign hit_rd = wr_en && (wr_addr == a1);
  assign h1     = wr_en && (wr_addr == p1_a);
  assign h2     = wr_en && (wr_addr == p2_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      init_idx  <= '0;
      ra        <= K_A;
      rt        <= K_T;
      rm        <= K_M;
      gen_count <= '0;
      best_fit  <= '0;
      v1        <= 1'b0;
      a1        <= '0;
      p1_ok     <= 1'b0;
      v2        <= 1'b0;
      st_v      <= '0;
    end else begin
      ra        <= lfsr_next(ra);
      rt        <= lfsr_next(rt);
      rm        <= lfsr_next(rm);
      gen_count <= gen_count + CNT_W'(child_valid);
      if (wr_en && wr_fit > best_fit) best_fit <= wr_fit;
      v1   <= (state == RUN) && !stop_now;
      a1   <= ra[ADDR_W-1:0];
      if (v1) p1_ok <= 1'b1;
      v2   <= v1 && p1_ok;
      st_v <= {st_v[1:0], v2};
      case (state)
        IDLE, STOP: if (start) begin
          state     <= INIT;
          init_idx  <= '0;
          gen_count <= '0;
          best_fit  <= '0;
          p1_ok     <= 1'b0;
          ra        <= mix(seed, K_A);
          rt        <= mix(seed, K_T);
          rm        <= mix(seed, K_M);
        end
        INIT: begin
          init_idx <= init_idx + 1'b1;
          if (&init_idx) state <= RUN;
        end
        RUN: if (stop_now) begin
          state <= STOP;
          p1_ok <= 1'b0;
          v2    <= 1'b0;
          st_v  <= '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_d[wr_addr] <= wr_data;
      mem_f[wr_addr] <= wr_fit;
    end
    if (v1) begin
      p1_a <= a1;
      p1_d <= hit_rd ? wr_data : mem_d[a1];
      p1_f <= hit_rd ? wr_fit  : mem_f[a1];
      p2_a <= p1_a;
      p2_d <= h1 ? wr_data : p1_d;
      p2_f <= h1 ? wr_fit  : p1_f;
    end else begin
      if (h1) begin p1_d <= wr_data; p1_f <= wr_fit; end
      if (h2) begin p2_d <= wr_data; p2_f <= wr_fit; end
    end

    st_d[0]  <= (tmpl & p1_d) | (~tmpl & p2_d);
    st_a1[0] <= p1_a;
    st_a2[0] <= p2_a;
    st_f1[0] <= h1 ? wr_fit : p1_f;
    st_f2[0] <= h2 ? wr_fit : p2_f;

    st_d[1]  <= st_d[0] ^ (mmask & {CHROM_W{mut_hit}});
    st_d[2]  <= st_d[1];
    e_fit    <= score(st_d[1]);

    for (int k = 1; k < 3; k++) begin
      st_a1[k] <= st_a1[k-1];
      st_a2[k] <= st_a2[k-1];
      st_f1[k] <= (wr_en && wr_addr == st_a1[k-1]) ? wr_fit : st_f1[k-1];
      st_f2[k] <= (wr_en && wr_addr == st_a2[k-1]) ? wr_fit : st_f2[k-1];
    end
  end
endmodule

// File: rtl/ssga_engine_props.sv
module ssga_engine_props #(
  parameter int FIT_W   = 7,
  parameter int CNT_W   = 32,
  parameter int FIT_MAX = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             wr_en,
  input logic [FIT_W-1:0] wr_fit,
  input logic             child_valid,
  input logic [FIT_W-1:0] child_fit,
  input logic [FIT_W-1:0] rival_fit,
  input logic [FIT_W-1:0] best_fit,
  input logic [CNT_W-1:0] gen_count,
  input logic             done
);
  assert_fit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_fit <= FIT_W'(FIT_MAX));

  assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(child_valid) |-> done);

  assert_survivor_fitter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (child_valid && wr_en) |-> (wr_fit > rival_fit && wr_fit == child_fit));

  assert_best_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> best_fit >= $past(best_fit));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_en && !child_valid));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    child_valid |=> gen_count == CNT_W'($past(gen_count) + 1'b1));
endmodule

bind ssga_engine ssga_engine_props #(
  .FIT_W(FIT_W), .CNT_W(CNT_W), .FIT_MAX(CHROM_W / BLOCK_W * BLOCK_WT)
) u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_fit(wr_fit),
  .child_valid(child_valid), .child_fit(child_fit), .rival_fit(rival_fit),
  .best_fit(best_fit), .gen_count(gen_count), .done(done)
);

// File: tb/ssga_engine_bench.sv
module ssga_engine_bench;
  localparam int CW = 16, BW = 4, BWT = 3, AW = 3, CNW = 16;
  localparam int NB = CW / BW, FMAX = NB * BWT, FW = $clog2(FMAX + 1), DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] seed = '0;
  logic [7:0] mut_thresh = '0;
  logic [CNW-1:0] max_children = '0;
  logic wr_en, child_valid, done;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic [FW-1:0] wr_fit, child_fit, rival_fit, best_fit;
  logic [CNW-1:0] gen_count;

  ssga_engine #(.CHROM_W(CW), .BLOCK_W(BW), .BLOCK_WT(BWT), .ADDR_W(AW), .CNT_W(CNW)) u_ssga_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .mut_thresh(mut_thresh),
    .max_children(max_children), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_fit(wr_fit), .child_valid(child_valid), .child_fit(child_fit), .rival_fit(rival_fit),
    .best_fit(best_fit), .gen_count(gen_count), .done(done));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fit_of(input logic [CW-1:0] d);
    int f = 0;
    for (int b = 0; b < NB; b++) if (&d[b*BW +: BW]) f += BWT;
    return f;
  endfunction

  task automatic run(input logic [31:0] sd, input logic [7:0] thr, input int maxc,
                     output int ngen, output int nbest);
    int c = 0, nk = 0, bmax = 0, lastsurv = -1;
    int sh [DEPTH];
    bit dn = 0;
    for (int i = 0; i < DEPTH; i++) sh[i] = 0;
    @(negedge clk);
    seed = sd; mut_thresh = thr; max_children = CNW'(maxc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!dn && c < 5000) begin
      chk(best_fit == bmax, "R7", best_fit, bmax);
      chk(gen_count == nk, "R9", gen_count, nk);
      if (done) begin
        dn = 1;
        chk(!child_valid && !wr_en, "R8", {child_valid, wr_en}, 0);
        chk(nk == maxc || (lastsurv == FMAX && nk < maxc), "R8", nk, maxc);
      end else begin
        if (c < DEPTH) begin
          chk(wr_en && !child_valid, "R2", {wr_en, child_valid}, 2);
          chk(wr_addr == c, "R2", wr_addr, c);
        end else begin
          if (nk > 0) chk(child_valid, "R4", child_valid, 1);
          if (wr_en) chk(child_valid, "R5", child_valid, 1);
          if (child_valid) begin
            chk(wr_en == (child_fit > rival_fit), "R5", wr_en, child_fit > rival_fit);
            if (wr_en) begin
              chk(wr_fit == child_fit, "R5", wr_fit, child_fit);
              chk(wr_fit > sh[wr_addr], "R6", wr_fit, sh[wr_addr] + 1);
              lastsurv = wr_fit;
            end
            nk++;
          end
        end
        if (wr_en) begin
          chk(wr_fit == fit_of(wr_data), "R3", wr_fit, fit_of(wr_data));
          sh[wr_addr] = wr_fit;
          if (wr_fit > bmax) bmax = wr_fit;
        end
      end
      c++;
      @(negedge clk);
    end
    if (!dn) chk(0, "R8 run timeout", c, 5000);
    ngen = gen_count;
    nbest = best_fit;
    repeat (3) @(negedge clk);
    chk(done && gen_count == ngen && best_fit == nbest, "R8", gen_count, ngen);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seeds [4];
    logic [7:0] thrs [3];
    int lims [3];
    int g0, b0, g1, b1;
    seeds[0] = 32'h0000_0000; seeds[1] = 32'h1D87_2B41;
    seeds[2] = 32'h1234_5678; seeds[3] = 32'hFFFF_FFFF;
    thrs[0] = 8'd0; thrs[1] = 8'd60; thrs[2] = 8'd220;
    lims[0] = 1; lims[1] = 37; lims[2] = 1200;

    repeat (2) @(negedge clk);
    chk(!done && !wr_en && !child_valid, "R1", {done, wr_en, child_valid}, 0);
    chk(best_fit == 0 && gen_count == 0, "R1", best_fit + gen_count, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && !wr_en && !child_valid, "R1", {done, wr_en, child_valid}, 0);
    chk(best_fit == 0 && gen_count == 0, "R1", best_fit + gen_count, 0);

    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 3; t++)
        for (int l = 0; l < 3; l++) run(seeds[s], thrs[t], lims[l], g0, b0);

    run(32'hCAFE_0042, 8'd90, 500, g0, b0);
    run(32'h0BAD_F00D, 8'd10, 80, g1, b1);
    run(32'hCAFE_0042, 8'd90, 500, g1, b1);
    chk(g1 == g0, "R10", g1, g0);
    chk(b1 == b0, "R10", b1, b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule